// File: doc/BRIEF.md
# Reduced-Area Wallace Tree Multiplier

This block multiplies two unsigned 8-bit operands and presents the full 16-bit product with no clock, no register and no handshake. The output follows the inputs after the combinational path settles. Surrounding logic registers the operands and the product wherever its own timing calls for it.

The product is built in three steps. An AND array forms the partial-product dots, one column for each product weight. A four-stage compression tree then shrinks every column to at most two bits. It uses full adders wherever three bits are available, and half adders only where a row limit would otherwise be broken. In every stage one extra half adder goes to the lowest column that still holds two bits. Its sum is then the only bit left at that weight, so each stage finishes one more low product bit. When two rows remain, the five lowest product bits are already final. A Kogge-Stone prefix adder therefore only has to cover the ten upper columns, and its carry out is the top product bit.

Top module: `rw_tree_mult`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals `op_a * op_b` as a 16-bit unsigned value.
- R2: `prod[0]` equals `op_a[0] & op_b[0]`. No compressor sits on its path.
- R3: Each full adder turns three dots of one weight into a sum dot of that weight and a carry dot one weight higher. Each half adder does the same with two dots. The arithmetic value of the tree is conserved, so products whose columns are all ones (such as 255 x 255 = 65025) come out exact.
- R4: The tree has four stages. After stages 1, 2, 3 and 4, no column holds more than 6, 4, 3 and 2 dots respectively.
- R5: After stage k (k = 1..4), column k holds exactly one dot, and that dot is `prod[k]`. `prod[4:0]` therefore never passes through the final adder and always equals the low five bits of the true product.
- R6: The final adder is a Kogge-Stone prefix adder, 10 bits wide, over columns 5 to 14. Its sum drives `prod[14:5]` and its carry out drives `prod[15]` (for example 255 x 255 gives `prod[15]` = 1 and 128 x 128 gives 0).
- R7: No carry is dropped. The highest column produces no carry in any stage, and the largest product 0xFE01 comes out whole.
- R8: `prod` depends only on the present operands. A change of operands shows on `prod` after combinational settling alone, and `prod` stays constant across clock edges while the operands are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product of `op_a` and `op_b` |

## Verification
Every result of this block is due zero clock cycles after its stimulus, because there is no register between `op_a`/`op_b` and `prod`. The bench changes the operands and samples `prod` one nanosecond later, well away from any clock edge. It then waits another nanosecond before the next change, so each sample sees exactly one settled operand pair. One directed case holds its operands across two clock edges and compares the product again, which shows that time passing does not alter the result.

// File: rtl/rw_pkg.sv
package rw_pkg;

  parameter int W = 8;

  localparam int NCOL = 2 * W;
  localparam int MAXH = W;

  typedef logic [NCOL-1:0][MAXH-1:0] dots_t;

  typedef struct packed {
    int hin;
    int nfa;
    int nha;
    int hout;
  } cplan_t;

  function automatic int num_stages();
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < W) begin
      n++;
      d = (d * 3) / 2;
    end
    return n;
  endfunction

  localparam int NSTG = num_stages();
  localparam int LOWN = NSTG + 1;
  localparam int FW   = NCOL - 1 - LOWN;

  // Height allowed after stage s (s = 0 is the first stage).
  function automatic int stage_limit(int s);
    int d;
    d = 2;
    for (int k = 0; k < NSTG - 1 - s; k++) d = (d * 3) / 2;
    return d;
  endfunction

  function automatic int init_height(int c);
    if (c < W) return c + 1;
    if (c < NCOL - 1) return NCOL - 1 - c;
    return 0;
  endfunction

  // Compressor plan of column col in stage stg. Full adders are taken greedily.
  // A half adder is added where the next height would break the limit, and
  // always at the lowest column holding two dots (this finishes a product bit).
  function automatic cplan_t plan_of(int stg, int col);
    int     h  [NCOL];
    int     hn [NCOL];
    int     cin;
    int     f;
    int     r;
    int     ha;
    int     lim;
    int     low;
    cplan_t res;
    res = '0;
    for (int c = 0; c < NCOL; c++) h[c] = init_height(c);
    for (int s = 0; s <= stg; s++) begin
      lim = stage_limit(s);
      low = -1;
      for (int c = 0; c < NCOL; c++)
        if (low < 0 && h[c] > 1) low = c;
      cin = 0;
      for (int c = 0; c < NCOL; c++) begin
        f  = h[c] / 3;
        r  = h[c] % 3;
        ha = 0;
        if (r >= 2 && (c == low || (r + f + cin) > lim)) ha = 1;
        hn[c] = (r - 2 * ha) + f + ha + cin;
        if (s == stg && c == col) res = '{h[c], f, ha, hn[c]};
        cin = f + ha;
      end
      for (int c = 0; c < NCOL; c++) h[c] = hn[c];
    end
    return res;
  endfunction

endpackage

// File: rtl/rw_fa.sv
module rw_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);

  assign s  = x ^ y ^ z;
  assign co = (x & y) | (z & (x ^ y));

  always_comb begin
    a_r3_fa_weight: assert ({co, s} == ({1'b0, x} + {1'b0, y} + {1'b0, z}));
  end

endmodule

// File: rtl/rw_ha.sv
module rw_ha (
  input  logic x,
  input  logic y,
  output logic s,
  output logic co
);

  assign s  = x ^ y;
  assign co = x & y;

  always_comb begin
    a_r3_ha_weight: assert ({co, s} == ({1'b0, x} + {1'b0, y}));
  end

endmodule

// File: rtl/rw_ppgen.sv
module rw_ppgen
  import rw_pkg::*;
(
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output dots_t        pp
);

  // Column c holds a[i] & b[c-i]; dots are packed from row 0 upward.
  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int LO = (c > W - 1) ? c - W + 1 : 0;
    localparam int H  = init_height(c);
    for (genvar j = 0; j < MAXH; j++) begin : g_dot
      if (j < H) begin : g_and
        assign pp[c][j] = a[LO + j] & b[c - LO - j];
      end else begin : g_zero
        assign pp[c][j] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/rw_stage.sv
module rw_stage
  import rw_pkg::*;
#(
  parameter int STG = 0
) (
  input  dots_t din,
  output dots_t dout
);

  localparam int LIM = stage_limit(STG);

  logic [NCOL-1:0][MAXH-1:0] cry;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam cplan_t P    = plan_of(STG, c);
    localparam int     USED = 3 * P.nfa + 2 * P.nha;
    localparam int     RL   = P.hin - USED;
    localparam int     NS   = P.nfa + P.nha;

    logic [MAXH-1:0] sm;
    logic [MAXH-1:0] cr;
    logic [MAXH-1:0] cin_v;

    for (genvar j = 0; j < MAXH; j++) begin : g_slot
      if (j < P.nfa) begin : g_full
        rw_fa u_fa (
          .x (din[c][3*j]),
          .y (din[c][3*j+1]),
          .z (din[c][3*j+2]),
          .s (sm[j]),
          .co(cr[j])
        );
      end else if (j == P.nfa && P.nha != 0) begin : g_half
        rw_ha u_ha (
          .x (din[c][USED-2]),
          .y (din[c][USED-1]),
          .s (sm[j]),
          .co(cr[j])
        );
      end else begin : g_none
        assign sm[j] = 1'b0;
        assign cr[j] = 1'b0;
      end
    end

    assign cry[c] = cr;

    if (c == 0) begin : g_nocin
      assign cin_v = '0;
    end else begin : g_cin
      assign cin_v = cry[c-1];
    end

    // Next column: untouched dots, then own sums, then carries from below.
    assign dout[c] = (din[c] >> USED) | (sm << RL) | (cin_v << (RL + NS));
  end

  always_comb begin
    for (int c = 0; c < NCOL; c++) begin
      for (int j = 0; j < MAXH; j++) begin
        if (j >= LIM) begin
          a_r4_row_limit: assert (!dout[c][j]);
        end
        if (j >= init_height(c)) begin
          a_r4_input_pad: assert (!(STG == 0 && din[c][j]));
        end
      end
      if (c <= STG + 1) begin
        a_r5_column_settled: assert (dout[c][MAXH-1:1] == '0);
      end
    end
    a_r7_no_carry_lost: assert (cry[NCOL-1] == '0);
  end

endmodule

// File: rtl/rw_ks_adder.sv
module rw_ks_adder #(
  parameter int N = 10
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N:0]   s
);

  localparam int LG = $clog2(N);

  logic [LG:0][N-1:0] g;
  logic [LG:0][N-1:0] pr;

  assign g[0]  = x & y;
  assign pr[0] = x ^ y;

  for (genvar l = 0; l < LG; l++) begin : g_lvl
    localparam int D = 1 << l;
    for (genvar i = 0; i < N; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign g[l+1][i]  = g[l][i] | (pr[l][i] & g[l][i-D]);
        assign pr[l+1][i] = pr[l][i] & pr[l][i-D];
      end else begin : g_pass
        assign g[l+1][i]  = g[l][i];
        assign pr[l+1][i] = pr[l][i];
      end
    end
  end

  assign s[0] = pr[0][0];
  for (genvar i = 1; i < N; i++) begin : g_sum
    assign s[i] = pr[0][i] ^ g[LG][i-1];
  end
  assign s[N] = g[LG][N-1];

  always_comb begin
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < N; i++) begin
      acc = acc & (x[i] ^ y[i]);
      a_r6_prefix_span: assert (pr[LG][i] == acc);
    end
    a_r6_prefix_sum: assert (s == ({1'b0, x} + {1'b0, y}));
  end

endmodule

// File: rtl/rw_tree_mult.sv
module rw_tree_mult
  import rw_pkg::*;
(
  input  logic [7:0]  op_a,
  input  logic [7:0]  op_b,
  output logic [15:0] prod
);

  dots_t lvl [NSTG+1];

  rw_ppgen u_pp (
    .a (op_a),
    .b (op_b),
    .pp(lvl[0])
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    rw_stage #(.STG(s)) u_stage (
      .din (lvl[s]),
      .dout(lvl[s+1])
    );
  end

  dots_t fin;
  assign fin = lvl[NSTG];

  for (genvar k = 0; k < LOWN; k++) begin : g_low
    assign prod[k] = fin[k][0];
  end

  logic [FW-1:0] row_x;
  logic [FW-1:0] row_y;
  logic [FW:0]   upper;

  for (genvar i = 0; i < FW; i++) begin : g_rows
    assign row_x[i] = fin[LOWN+i][0];
    assign row_y[i] = fin[LOWN+i][1];
  end

  rw_ks_adder #(.N(FW)) u_final (
    .x(row_x),
    .y(row_y),
    .s(upper)
  );

  assign prod[NCOL-1:LOWN] = upper;

  logic [NCOL-1:0] chk_ref;
  assign chk_ref = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  always_comb begin
    a_r1_product: assert (prod == chk_ref);
    a_r2_lsb: assert (prod[0] == (op_a[0] & op_b[0]));
    a_r5_early_bits: assert (prod[LOWN-1:0] == chk_ref[LOWN-1:0]);
    for (int c = 0; c < NCOL; c++) begin
      for (int j = 0; j < MAXH; j++) begin
        if (j >= 2 || c == NCOL - 1 || (c < LOWN && j >= 1)) begin
          a_r6_two_rows: assert (!fin[c][j]);
        end
      end
    end
  end

endmodule

// File: tb/tb_rw_tree_mult.sv
`timescale 1ns/1ps
module tb_rw_tree_mult;

  localparam int WD_LIMIT = 150000;

  logic        clk;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [15:0] prod;

  int checks;
  int errors;
  int cycles;
  bit done;

  rw_tree_mult dut (
    .op_a(op_a),
    .op_b(op_b),
    .prod(prod)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_prod(logic [7:0] x, logic [7:0] y);
    return {8'd0, x} * {8'd0, y};
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d got 0x%0h expected 0x%0h", tag, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(logic [7:0] x, logic [7:0] y);
    op_a = x;
    op_b = y;
    #1;
  endtask

  task automatic directed(logic [7:0] x, logic [7:0] y);
    logic [15:0] e;
    apply(x, y);
    e = exp_prod(x, y);
    check("R1 product", prod, e);
    check("R2 bit0", {15'd0, prod[0]}, {15'd0, x[0] & y[0]});
    check("R5 low five bits", {11'd0, prod[4:0]}, {11'd0, e[4:0]});
    check("R6 carry out bit15", {15'd0, prod[15]}, {15'd0, e[15]});
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer than %0d", cycles, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    cycles = 0;
    done   = 1'b0;
    op_a   = 8'd0;
    op_b   = 8'd0;
    #1;
    check("R1 idle zero operands", prod, 16'd0);

    directed(8'hFF, 8'hFF);   // R3 all-ones columns, R7 largest product
    check("R7 largest product", prod, 16'hFE01);
    check("R3 dense columns", prod, 16'd65025);
    directed(8'h80, 8'h80);   // R6 no carry out
    directed(8'h01, 8'hA5);
    directed(8'hFF, 8'h01);
    directed(8'h1F, 8'h1F);   // R5 low columns busy
    directed(8'hAA, 8'h55);   // R4 alternating rows
    check("R4 alternating rows", prod, 16'd14450);
    directed(8'hFE, 8'hFF);

    // R8: hold operands across clock edges; result must not move.
    apply(8'hC3, 8'h7B);
    check("R8 settled after change", prod, exp_prod(8'hC3, 8'h7B));
    @(posedge clk);
    @(posedge clk);
    #3;
    check("R8 stable across clock edges", prod, exp_prod(8'hC3, 8'h7B));

    // R1: every operand pair.
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 256; j++) begin
        apply(i[7:0], j[7:0]);
        check("R1 exhaustive", prod, exp_prod(i[7:0], j[7:0]));
        #1;
      end
    end

    // Seeded random mix, low bits checked on their own as well.
    void'($urandom(32'd20240611));
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] x;
      logic [7:0] y;
      x = 8'($urandom);
      y = 8'($urandom);
      apply(x, y);
      check("R1 random", prod, exp_prod(x, y));
      check("R5 random low bits", {11'd0, prod[4:0]}, {11'd0, exp_prod(x, y) & 16'h001F});
      #1;
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule